// File: doc/BRIEF.md
# Battery Low Check Sequencer

This block decides when a battery comparator is sampled and owns the battery-low status bit that results. A check begins when main power comes back after a stretch on backup supply, and again each time the timekeeping counters wrap at midnight while the part runs from main power. A midnight wrap seen while still on backup supply starts nothing.

Each check can switch a test load onto the battery and waits a programmable number of settling cycles. It then samples the comparator output, drops the load and writes the result into the status bit. A rollover check always loads the battery. A power-return check loads it only when the configuration input selects that variant. The status bit is also presented inside an 8-bit flag byte at the bit position the register decoder expects.

Triggers that arrive while a check is running are remembered, one per kind, and run after it.

Top module: `bat_chk_seq`

## Requirements
- R1: While rst_ni is low, load_en_o, bat_low_o and flags_o are all 0, including when a check was running.
- R2: A high cycle on bkp_exit_i starts a check; if cmp_low_i is 1 (battery under the reference) when sampled, bat_low_o becomes 1.
- R3: A check that samples cmp_low_i as 0 clears bat_low_o.
- R4: A high cycle on midnight_i while in_backup_i is 0 starts a check with load_en_o high for the whole check.
- R5: A high cycle on midnight_i while in_backup_i is 1 is ignored: no load is applied and bat_low_o keeps its value.
- R6: A power-return check keeps load_en_o low when load_pwrup_i is 0 at its start, and drives it high for the whole check when load_pwrup_i is 1.
- R7: With SETTLE_CYC = N, a check occupies N+1 cycles starting at the clock edge that samples the trigger. The comparator is sampled at the next edge. At that same edge bat_low_o takes its new value and load_en_o returns to 0.
- R8: Triggers of one kind arriving during a check collapse into a single further check, which starts one cycle after the current one ends.
- R9: When both kinds are waiting, the power-return check runs before the rollover check.
- R10: flags_o carries bat_low_o at bit 4, and its other seven bits are 0.
- R11: bat_low_o changes only at the end of a check; comparator changes between checks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bkp_exit_i | input | 1 | One-cycle pulse: main power restored after backup |
| midnight_i | input | 1 | One-cycle pulse: counters wrapped at midnight |
| in_backup_i | input | 1 | Level: running from backup supply |
| cmp_low_i | input | 1 | Comparator: battery below reference |
| load_pwrup_i | input | 1 | Configuration: also load battery on power-return checks |
| load_en_o | output | 1 | Battery test load enable |
| bat_low_o | output | 1 | Battery-low status bit |
| flags_o | output | 8 | Flag byte, battery-low at bit 4 |

## Verification
The bench changes the comparator in the last settling cycle, so a design that sampled early or late would record a stale value. It issues repeated and mixed triggers during a check. Lost triggers would show up as a missing load pulse, duplicated ones as an extra pulse, and the wrong priority as a one-cycle gap where an eleven-cycle gap is expected. Midnight pulses during backup are checked to leave both the load and the status untouched. A reset in the middle of a loaded check must drop the load at once.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_SAMPLE} bl_state_e;
  typedef enum logic {CHK_PWRUP, CHK_ROLL} bl_kind_e;
  localparam int unsigned FLAG_W      = 8;
  localparam int unsigned FLAG_BL_BIT = 4;
endpackage

// File: rtl/bl_trig_queue.sv
module bl_trig_queue
  import bl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bkp_exit_i,
  input  logic     midnight_i,
  input  logic     in_backup_i,
  input  logic     idle_i,
  output logic     start_o,
  output bl_kind_e kind_o
);
  logic pend_pu_q, pend_ro_q;
  logic req_pu, req_ro;

  // midnight is only honoured on main power
  assign req_pu  = bkp_exit_i | pend_pu_q;
  assign req_ro  = (midnight_i & ~in_backup_i) | pend_ro_q;
  assign start_o = idle_i & (req_pu | req_ro);
  assign kind_o  = req_pu ? CHK_PWRUP : CHK_ROLL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_pu_q <= 1'b0;
      pend_ro_q <= 1'b0;
    end else if (start_o) begin
      pend_pu_q <= 1'b0;
      pend_ro_q <= (kind_o == CHK_ROLL) ? 1'b0 : req_ro;
    end else begin
      pend_pu_q <= req_pu;
      pend_ro_q <= req_ro;
    end
  end
endmodule

// File: rtl/bl_settle_timer.sv
module bl_settle_timer #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign done_o = run_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bl_status_reg.sv
module bl_status_reg
  import bl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              cmp_low_i,
  output logic              bl_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic bl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bl_q <= 1'b0;
    else if (sample_i) bl_q <= cmp_low_i;
  end

  assign bl_o = bl_q;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (i == FLAG_BL_BIT) begin : g_bl
      assign flags_o[i] = bl_q;
    end else begin : g_zero
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bat_chk_seq.sv
module bat_chk_seq
  import bl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bkp_exit_i,
  input  logic       midnight_i,
  input  logic       in_backup_i,
  input  logic       cmp_low_i,
  input  logic       load_pwrup_i,
  output logic       load_en_o,
  output logic       bat_low_o,
  output logic [7:0] flags_o
);
  bl_state_e state_q;
  bl_kind_e  kind_q, kind_nx;
  logic      load_q, start, settle_done, idle, sample_en;

  assign idle      = (state_q == ST_IDLE);
  assign sample_en = (state_q == ST_SAMPLE);

  bl_trig_queue u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bkp_exit_i  (bkp_exit_i),
    .midnight_i  (midnight_i),
    .in_backup_i (in_backup_i),
    .idle_i      (idle),
    .start_o     (start),
    .kind_o      (kind_nx)
  );

  bl_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .done_o  (settle_done)
  );

  bl_status_reg u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_en),
    .cmp_low_i (cmp_low_i),
    .bl_o      (bat_low_o),
    .flags_o   (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= CHK_PWRUP;
      load_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SETTLE;
          kind_q  <= kind_nx;
          load_q  <= (kind_nx == CHK_ROLL) | load_pwrup_i;
        end
        ST_SETTLE: if (settle_done) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          state_q <= ST_IDLE;
          load_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_en_o = load_q;
endmodule

// File: rtl/bl_chk.sv
module bl_chk
  import bl_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_en_o,
  input logic       bat_low_o,
  input logic [7:0] flags_o,
  input bl_state_e  state_q,
  input bl_kind_e   kind_q
);
  a_r11_bl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SAMPLE) |=> $stable(bat_low_o));

  a_r7_load_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE) |=> !load_en_o);

  a_r7_sample_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE) |-> ($past(state_q) == ST_SETTLE));

  a_r7_idle_unloaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !load_en_o);

  a_r4_roll_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && kind_q == CHK_ROLL) |-> load_en_o);

  a_r10_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FLAG_BL_BIT] == bat_low_o) && ($countones(flags_o) <= 1));
endmodule

bind bat_chk_seq bl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_en_o (load_en_o),
  .bat_low_o (bat_low_o),
  .flags_o   (flags_o),
  .state_q   (state_q),
  .kind_q    (kind_q)
);

// File: tb/sim_bat_chk_seq.sv
module sim_bat_chk_seq;
  localparam int N = 8;
  // [8] midnight(1)/exit(0) [7] in_backup [6] cfg [5] cmp [4:1] load cycles [0] bl
  localparam logic [8:0] VEC [8] = '{
    9'b0_0_0_1_0000_1,
    9'b1_0_0_0_1001_0,
    9'b1_0_0_1_1001_1,
    9'b1_1_0_0_0000_1,
    9'b0_0_1_0_1001_0,
    9'b0_0_0_0_0000_0,
    9'b1_1_1_1_0000_0,
    9'b0_0_1_1_1001_1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bkp_exit = 1'b0, midnight = 1'b0, in_backup = 1'b0, cmp_low = 1'b0, cfg = 1'b0;
  logic load_en, bat_low;
  logic [7:0] flags;

  int total = 0, fails = 0;
  int hi_cnt = 0, rise_cnt = 0, low_run = 0, last_gap = 0;
  logic prev_load = 1'b0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  bat_chk_seq #(.SETTLE_CYC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bkp_exit_i(bkp_exit), .midnight_i(midnight),
    .in_backup_i(in_backup), .cmp_low_i(cmp_low), .load_pwrup_i(cfg),
    .load_en_o(load_en), .bat_low_o(bat_low), .flags_o(flags)
  );

  always @(negedge clk) begin
    if (load_en) hi_cnt++;
    if (load_en && !prev_load) begin
      rise_cnt++;
      last_gap = low_run;
    end
    low_run = load_en ? 0 : low_run + 1;
    prev_load = load_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit mid, input bit clr);
    @(negedge clk);
    #1;
    if (clr) begin
      hi_cnt = 0; rise_cnt = 0; low_run = 0; last_gap = 0; prev_load = 1'b0;
    end
    if (mid) midnight = 1'b1; else bkp_exit = 1'b1;
    @(negedge clk);
    midnight = 1'b0;
    bkp_exit = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(load_en == 0 && bat_low == 0 && flags == 0, "R1 reset", int'(flags), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_backup = VEC[i][7];
      cfg       = VEC[i][6];
      cmp_low   = VEC[i][5];
      pulse(VEC[i][8], 1'b1);
      repeat (16) @(negedge clk);
      chk(hi_cnt == int'(VEC[i][4:1]),
          VEC[i][8] ? (VEC[i][7] ? "R5 load" : "R4 load") : "R6 load",
          hi_cnt, int'(VEC[i][4:1]));
      chk(bat_low == VEC[i][0], VEC[i][7] ? "R5 bl" : (VEC[i][5] ? "R2 bl" : "R3 bl"),
          int'(bat_low), int'(VEC[i][0]));
      chk(flags == {3'b0, VEC[i][0], 4'b0}, "R10 flags", int'(flags),
          int'({3'b0, VEC[i][0], 4'b0}));
    end

    // R7: sample point is the edge after the last settle cycle
    in_backup = 1'b0; cfg = 1'b0; cmp_low = 1'b1;
    pulse(1'b1, 1'b1);
    repeat (8) @(negedge clk);
    cmp_low = 1'b0;
    chk(bat_low == 1 && load_en == 1, "R7 before sample", int'({bat_low, load_en}), 3);
    @(negedge clk);
    chk(bat_low == 0 && load_en == 0, "R7 after sample", int'({bat_low, load_en}), 0);

    // R11: comparator moves with no check running
    cmp_low = 1'b1;
    repeat (5) @(negedge clk);
    chk(bat_low == 0 && load_en == 0, "R11 idle cmp", int'(bat_low), 0);

    // R8: repeated rollover triggers during a check
    pulse(1'b1, 1'b1);
    repeat (2) @(negedge clk);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk(rise_cnt == 2, "R8 runs", rise_cnt, 2);
    chk(hi_cnt == 18, "R8 load cycles", hi_cnt, 18);
    chk(last_gap == 1, "R8 gap", last_gap, 1);

    // R9: power-return waits ahead of rollover
    cfg = 1'b0;
    pulse(1'b1, 1'b1);
    repeat (2) @(negedge clk);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b0);
    repeat (45) @(negedge clk);
    chk(rise_cnt == 2, "R9 runs", rise_cnt, 2);
    chk(last_gap == 11, "R9 order gap", last_gap, 11);

    // R1: reset in the middle of a loaded check
    cmp_low = 1'b1;
    pulse(1'b1, 1'b1);
    repeat (12) @(negedge clk);
    chk(bat_low == 1, "R2 pre-reset", int'(bat_low), 1);
    pulse(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(load_en == 0 && bat_low == 0 && flags == 0, "R1 mid-check reset",
        int'({load_en, bat_low}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(load_en == 0, "R1 after reset", int'(load_en), 0);

    finish_run();
  end
endmodule